// File: doc/BRIEF.md
# PS/2 keyboard serial receiver

This block receives the serial frames a keyboard sends over a two-wire clock/data link. It delivers each byte, after checking it, to the controller core. Both lines are resampled in the system clock domain through two flops. The keyboard clock is then debounced, and each debounced falling edge takes one sample of the data line. A low sample while idle opens a frame. The next eight samples are the data bits, least significant first. One parity sample and one stop sample close the frame.

When a frame completes, the byte appears with a one-cycle valid strobe. The same strobe carries an error flag that is set when the odd-parity check fails or when the stop bit reads low. A frame that has not finished within a programmable number of cycles after its start bit is dropped, and a separate timeout strobe is raised. These strobes are meant to feed the status register. The block pulls the keyboard clock low while software requests an inhibit, or while the host output buffer still holds a byte, so that no new frame can begin. A pull requested during a frame waits until that frame has ended. The resampled line levels are also provided as two test readbacks.

Top module: `ps2_kbd_rx`

## Requirements
- R1: A frame is one start bit (0), eight data bits with the least significant first, one parity bit and one stop bit. The byte appears on `rxByte` with `rxValid` high for exactly one cycle. `rxValid` rises DEB_CYCLES+3 clock edges after the line change that forms the falling edge of the stop bit.
- R2: Parity is odd. When the eight data bits and the parity bit together hold an even number of ones, `parityErr` is high in the same cycle as `rxValid`. Otherwise `parityErr` stays low.
- R3: A stop bit that samples as 0 also raises `parityErr` together with `rxValid`, and the byte is still delivered.
- R4: The data line is sampled only on debounced falling edges of the keyboard clock. A low pulse on the clock line shorter than DEB_CYCLES cycles is ignored, and it opens no frame even while the data line is low.
- R5: If a frame has not completed TIMEOUT_CYCLES cycles after the receiver has accepted its start bit, the frame is aborted and `timeoutErr` is high for one cycle. `rxValid` is not raised, and the receiver returns to idle, so the next frame is received normally.
- R6: `kbClkHoldLow` is 1 while `inhibitReq` or `bufFull` is 1 and no frame is in progress. A request that arrives during a frame takes effect only after that frame ends. The output falls one edge after both requests drop.
- R7: While `kbClkHoldLow` is 1, clock activity on the line produces no byte and no error strobe.
- R8: `testClk` and `testData` show the levels of `kbClkIn` and `kbDataIn` two clock edges later.
- R9: After reset, `rxValid`, `parityErr`, `timeoutErr` and `kbClkHoldLow` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| kbClkIn | input | 1 | Keyboard clock line level |
| kbDataIn | input | 1 | Keyboard data line level |
| inhibitReq | input | 1 | Software request to inhibit the keyboard |
| bufFull | input | 1 | Host output buffer still holds a byte |
| kbClkHoldLow | output | 1 | 1 = pull keyboard clock line low (inhibit state) |
| rxByte | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe: byte ready |
| parityErr | output | 1 | Parity or stop-bit error, with rxValid |
| timeoutErr | output | 1 | One-cycle strobe: frame aborted on timeout |
| testClk | output | 1 | Resampled keyboard clock level |
| testData | output | 1 | Resampled keyboard data level |

## Verification
If the bit counter slips, the frame boundary moves. The result is a byte that is shifted, a false parity error, or a strobe at the wrong time, and each one shows on the ports within a frame. A stuck or leaking timeout counter shows up as a missing abort strobe or a premature one, exactly TIMEOUT_CYCLES after the start bit. The deferred pull on the clock line shows up at once at `kbClkHoldLow`. A receiver left mid-frame in error makes the following good frame come out misaligned.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  typedef enum logic [0:0] {ST_IDLE, ST_RECV} rxState_t;

  typedef struct packed {
    logic startFrame;
    logic shiftBit;
    logic finish;
    logic abort;
  } rxStrobe_t;
endpackage

// File: rtl/ps2_rx_datapath.sv
module ps2_rx_datapath
  import ps2_rx_pkg::*;
#(
  parameter int DEB_CYCLES = 8,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 kbClkIn,
  input  logic                 kbDataIn,
  input  rxStrobe_t            strb,
  output logic                 fallPulse,
  output logic                 sampledBit,
  output logic                 testClk,
  output logic                 testData,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 timeoutErr
);
  localparam int FRAME_BITS = DATA_BITS + 1;
  localparam int DEB_W      = $clog2(DEB_CYCLES + 1);

  logic [1:0]            clkSync, dataSync;
  logic                  clkStable;
  logic [DEB_W-1:0]      debCnt;
  logic [FRAME_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSync  <= 2'b11;
      dataSync <= 2'b11;
    end else begin
      clkSync  <= {clkSync[0], kbClkIn};
      dataSync <= {dataSync[0], kbDataIn};
    end
  end

  assign testClk  = clkSync[1];
  assign testData = dataSync[1];

  // debounce: a level must differ for DEB_CYCLES cycles before it is taken
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkStable  <= 1'b1;
      debCnt     <= '0;
      fallPulse  <= 1'b0;
      sampledBit <= 1'b1;
    end else begin
      fallPulse <= 1'b0;
      if (clkSync[1] == clkStable) begin
        debCnt <= '0;
      end else if (debCnt == DEB_W'(DEB_CYCLES - 1)) begin
        clkStable <= clkSync[1];
        debCnt    <= '0;
        if (!clkSync[1]) begin
          fallPulse  <= 1'b1;
          sampledBit <= dataSync[1];
        end
      end else begin
        debCnt <= debCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg   <= '0;
      rxByte     <= '0;
      rxValid    <= 1'b0;
      parityErr  <= 1'b0;
      timeoutErr <= 1'b0;
    end else begin
      if (strb.startFrame) shiftReg <= '0;
      else if (strb.shiftBit) shiftReg <= {sampledBit, shiftReg[FRAME_BITS-1:1]};
      rxValid    <= strb.finish;
      timeoutErr <= strb.abort;
      parityErr  <= 1'b0;
      if (strb.finish) begin
        rxByte    <= shiftReg[DATA_BITS-1:0];
        parityErr <= ~(^shiftReg) | ~sampledBit;
      end
    end
  end

  assert_err_with_byte_R2: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |-> rxValid);
  assert_timeout_no_byte_R5: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> !rxValid);
  assert_fall_on_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    fallPulse |-> !clkStable);
  assert_valid_single_R1: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
endmodule

// File: rtl/ps2_rx_control.sv
module ps2_rx_control
  import ps2_rx_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 500000,
  parameter int FRAME_BITS     = 9
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fallPulse,
  input  logic      sampledBit,
  input  logic      inhibitReq,
  input  logic      bufFull,
  output rxStrobe_t strb,
  output logic      kbClkHoldLow
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam int TO_W  = $clog2(TIMEOUT_CYCLES + 1);

  rxState_t         state, nextState;
  logic [CNT_W-1:0] bitCnt;
  logic [TO_W-1:0]  tCnt;
  logic             edgeSeen;

  assign edgeSeen = fallPulse & ~kbClkHoldLow;

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (edgeSeen && !sampledBit) begin
        strb.startFrame = 1'b1;
        nextState       = ST_RECV;
      end
      default: begin
        if (tCnt == TO_W'(TIMEOUT_CYCLES - 1)) begin
          strb.abort = 1'b1;
          nextState  = ST_IDLE;
        end else if (edgeSeen) begin
          if (bitCnt == CNT_W'(FRAME_BITS)) begin
            strb.finish = 1'b1;
            nextState   = ST_IDLE;
          end else begin
            strb.shiftBit = 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      bitCnt       <= '0;
      tCnt         <= '0;
      kbClkHoldLow <= 1'b0;
    end else begin
      state        <= nextState;
      kbClkHoldLow <= (inhibitReq | bufFull) & (nextState == ST_IDLE);
      if (strb.startFrame) begin
        bitCnt <= '0;
        tCnt   <= '0;
      end else if (state == ST_RECV) begin
        tCnt <= tCnt + 1'b1;
        if (strb.shiftBit) bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assert_bitcnt_range_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV) |-> (bitCnt <= CNT_W'(FRAME_BITS)));
  assert_hold_only_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    kbClkHoldLow |-> (state == ST_IDLE));
  assert_timer_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RECV) |-> (tCnt < TO_W'(TIMEOUT_CYCLES)));
endmodule

// File: rtl/ps2_kbd_rx.sv
module ps2_kbd_rx
  import ps2_rx_pkg::*;
#(
  parameter int DEB_CYCLES     = 8,
  parameter int TIMEOUT_CYCLES = 500000,
  parameter int DATA_BITS      = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 kbClkIn,
  input  logic                 kbDataIn,
  input  logic                 inhibitReq,
  input  logic                 bufFull,
  output logic                 kbClkHoldLow,
  output logic [DATA_BITS-1:0] rxByte,
  output logic                 rxValid,
  output logic                 parityErr,
  output logic                 timeoutErr,
  output logic                 testClk,
  output logic                 testData
);
  rxStrobe_t strb;
  logic      fallPulse, sampledBit;

  ps2_rx_datapath #(.DEB_CYCLES(DEB_CYCLES), .DATA_BITS(DATA_BITS)) u_datapath (
    .clk(clk), .rstN(rstN), .kbClkIn(kbClkIn), .kbDataIn(kbDataIn), .strb(strb),
    .fallPulse(fallPulse), .sampledBit(sampledBit), .testClk(testClk),
    .testData(testData), .rxByte(rxByte), .rxValid(rxValid),
    .parityErr(parityErr), .timeoutErr(timeoutErr)
  );

  ps2_rx_control #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .FRAME_BITS(DATA_BITS + 1)) u_control (
    .clk(clk), .rstN(rstN), .fallPulse(fallPulse), .sampledBit(sampledBit),
    .inhibitReq(inhibitReq), .bufFull(bufFull), .strb(strb),
    .kbClkHoldLow(kbClkHoldLow)
  );
endmodule

// File: tb/ps2_kbd_rx_bench.sv
`timescale 1ns/1ps
module ps2_kbd_rx_bench;
  localparam int DEB = 4;
  localparam int TO  = 1000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic kbClkKb = 1'b1, kbData = 1'b1, inhibitReq = 1'b0, bufFull = 1'b0;
  logic kbClkHoldLow, rxValid, parityErr, timeoutErr, testClk, testData;
  logic [7:0] rxByte;
  logic kbClkLine;

  assign kbClkLine = kbClkKb & ~kbClkHoldLow;

  ps2_kbd_rx #(.DEB_CYCLES(DEB), .TIMEOUT_CYCLES(TO), .DATA_BITS(8)) u_ps2_kbd_rx (
    .clk(clk), .rstN(rstN), .kbClkIn(kbClkLine), .kbDataIn(kbData),
    .inhibitReq(inhibitReq), .bufFull(bufFull), .kbClkHoldLow(kbClkHoldLow),
    .rxByte(rxByte), .rxValid(rxValid), .parityErr(parityErr),
    .timeoutErr(timeoutErr), .testClk(testClk), .testData(testData)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    int       at;
    logic [7:0] b;
    bit       pe;
    bit       te;
    string    tag;
  } event_t;
  event_t expQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // per-cycle comparison against the expected event schedule
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (expQ.size() > 0 && expQ[0].at < cyc) begin
        check(0, {expQ[0].tag, " missed event"}, 0, 1);
        void'(expQ.pop_front());
      end
      if (expQ.size() > 0 && expQ[0].at == cyc) begin
        if (expQ[0].te) begin
          check(timeoutErr == 1'b1 && rxValid == 1'b0, {expQ[0].tag, " timeout strobe"},
                {rxValid, timeoutErr}, 1);
        end else begin
          check(rxValid == 1'b1, {expQ[0].tag, " valid"}, rxValid, 1);
          check(rxByte == expQ[0].b, {expQ[0].tag, " byte"}, rxByte, expQ[0].b);
          check(parityErr == expQ[0].pe, {expQ[0].tag, " error flag"}, parityErr, expQ[0].pe);
        end
        void'(expQ.pop_front());
      end else if (rxValid || timeoutErr || parityErr) begin
        check(0, "R1 R7 unexpected strobe", {rxValid, parityErr, timeoutErr}, 0);
      end
    end
  end

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pushEv(input int at, input logic [7:0] b, input bit pe, input bit te,
                        input string tag);
    event_t e;
    e.at = at; e.b = b; e.pe = pe; e.te = te; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic sendFrame(input logic [7:0] b, input bit badPar, input bit stopBit,
                           input bit expectOut, input string tag);
    logic [10:0] bits;
    logic par;
    par  = ~(^b) ^ badPar;
    bits = {stopBit, par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      kbData = bits[i];
      waitN(10);
      kbClkKb = 1'b0;
      if (i == 10 && expectOut) pushEv(cyc + DEB + 3, b, badPar | ~stopBit, 0, tag);
      waitN(20);
      kbClkKb = 1'b1;
      waitN(10);
    end
    kbData = 1'b1;
    waitN(20);
  endtask

  task automatic finishRun();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    int startAt;
    waitN(3);
    check(rxValid == 0 && parityErr == 0 && timeoutErr == 0 && kbClkHoldLow == 0,
          "R9 outputs in reset", {rxValid, parityErr, timeoutErr, kbClkHoldLow}, 0);
    rstN = 1'b1;
    waitN(3);
    check(kbClkHoldLow == 0, "R9 hold after reset", kbClkHoldLow, 0);

    // R8: test readbacks follow the lines after two edges
    kbData = 1'b0;
    waitN(2);
    check(testData == 1'b0 && testClk == 1'b1, "R8 readback", {testClk, testData}, 2);
    kbData = 1'b1;
    waitN(2);
    check(testData == 1'b1, "R8 readback restore", testData, 1);
    waitN(10);

    // R1 and R2: good frames with several patterns
    sendFrame(8'hA5, 0, 1, 1, "R1 frame A5");
    sendFrame(8'h01, 0, 1, 1, "R1 frame 01 lsb first");
    sendFrame(8'h00, 0, 1, 1, "R2 frame 00 odd parity");
    sendFrame(8'hFF, 0, 1, 1, "R2 frame FF odd parity");
    // R2: wrong parity
    sendFrame(8'h3C, 1, 1, 1, "R2 bad parity");
    // R3: stop bit low
    sendFrame(8'h5A, 0, 0, 1, "R3 stop bit low");

    // R4: short glitch on the clock while data is low
    kbData = 1'b0;
    waitN(10);
    kbClkKb = 1'b0;
    waitN(DEB - 2);
    kbClkKb = 1'b1;
    waitN(10);
    kbData = 1'b1;
    waitN(20);
    sendFrame(8'h96, 0, 1, 1, "R4 frame after glitch");

    // R5: start bit, then silence
    kbData = 1'b0;
    waitN(10);
    kbClkKb = 1'b0;
    startAt = cyc;
    pushEv(startAt + DEB + 3 + TO, 8'h00, 0, 1, "R5 timeout");
    waitN(20);
    kbClkKb = 1'b1;
    waitN(10);
    kbData = 1'b1;
    waitN(TO + 40);
    check(expQ.size() == 0, "R5 timeout seen", expQ.size(), 0);
    sendFrame(8'hC3, 0, 1, 1, "R5 frame after timeout");

    // R6: inhibit request in idle
    inhibitReq = 1'b1;
    waitN(2);
    check(kbClkHoldLow == 1'b1, "R6 hold on inhibit", kbClkHoldLow, 1);
    waitN(3);
    check(testClk == 1'b0, "R6 line pulled low", testClk, 0);
    // R7: keyboard tries to send while held
    sendFrame(8'h77, 0, 1, 0, "R7 held frame");
    inhibitReq = 1'b0;
    waitN(2);
    check(kbClkHoldLow == 1'b0, "R6 release", kbClkHoldLow, 0);
    waitN(30);

    // R6: buffer-full request raised mid-frame is deferred
    fork
      sendFrame(8'h4E, 0, 1, 1, "R6 frame with late full");
      begin
        waitN(150);
        bufFull = 1'b1;
        waitN(5);
        check(kbClkHoldLow == 1'b0, "R6 deferred during frame", kbClkHoldLow, 0);
      end
    join
    check(kbClkHoldLow == 1'b1, "R6 hold after frame", kbClkHoldLow, 1);
    bufFull = 1'b0;
    waitN(2);
    check(kbClkHoldLow == 1'b0, "R6 release full", kbClkHoldLow, 0);
    waitN(30);
    sendFrame(8'h81, 0, 1, 1, "R1 final frame");
    waitN(20);
    check(expQ.size() == 0, "R1 all events seen", expQ.size(), 0);
    finishRun();
  end
endmodule